// File: doc/BRIEF.md
# Multi-Mode Program Trace Buffer

This block records program-flow or bus-cycle lines into a circular store while a trace session runs. The session starts when the sequencer's trigger-active flag rises and lasts while the flag stays high. A capture filter, chosen by a two-bit mode input, decides which cycles produce a line:
- change-of-flow events;
- change-of-flow events with back-to-back duplicate sources dropped;
- every qualifying data bus cycle, with direction and size;
- every program counter value.

Capture is inhibited while the secure input is high.

Each line holds three 16-bit words: a header, an address word and a payload word. When the trigger flag drops, a read pointer is set to the oldest stored line. Software then drains the buffer through one 16-bit read port. Each read strobe steps to the next word, and after the third word to the next line. The block also outputs a line count and a flag showing that old lines were overwritten.

Top module: `trace_buf`

## Requirements
- R1: After reset, `entryCnt` is 0, `wrapped` is 0 and `rdData` is 0.
- R2: Lines are written only on a clock edge where `traceArm` is high and `secure` is low. The edge where `traceArm` is first seen high (its rise) empties the buffer, clears `wrapped` and forgets the last stored source. A line that qualifies in that same cycle is written as the first line.
- R3: In mode 0 (flow), each cycle with `cofValid` high stores one line: header 0x0000, then `cpuPc` (the source), then `cofDest`.
- R4: In mode 1 (flow, deduplicated), the line is the same as R3 but with header 0x0001. A `cofValid` cycle is skipped when `cpuPc` equals the source of the last line stored in this session. A repeat that is not back-to-back is still stored.
- R5: In mode 2 (detail), a cycle stores a line unless `cycKind` is 00 (free) or 01 (opcode fetch). The header is 0x0002, with bit 2 set to `busWrite` and bit 3 set to `busWord`. The other two words are `busAddr` and `busData`.
- R6: In mode 3 (all PC), each cycle with `pcValid` high stores a line: header 0x0003, then `cpuPc`, then 0x0000.
- R7: While `secure` is high, no line is stored and `entryCnt` does not change.
- R8: `entryCnt` counts the lines stored in the session and stops at 64. A line stored when the count is already 64 overwrites the oldest line and sets `wrapped`. `wrapped` is never set while `entryCnt` is below 64.
- R9: The edge where `traceArm` is seen falling points the reader at word 0 of the oldest line. That line is line 0 if `wrapped` is 0, and otherwise the line after the newest. Each `rdStrobe` with `traceArm` low moves to the next word in the order header, address, payload, then to the next line, cycling through the store.
- R10: `rdData` is 0 and `rdStrobe` has no effect while `traceArm` is high. `rdData` is also 0 while `entryCnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| traceArm | input | 1 | Trigger-active flag from the sequencer |
| secure | input | 1 | Secured-system flag; blocks capture |
| modeSel | input | 2 | Capture filter: 0 flow, 1 deduplicated flow, 2 detail, 3 all PC |
| pcValid | input | 1 | Program counter valid this cycle |
| cpuPc | input | 16 | Current program counter; source of a change of flow |
| cofValid | input | 1 | Change-of-flow event this cycle |
| cofDest | input | 16 | Destination of the change of flow |
| cycKind | input | 2 | Bus cycle kind: 00 free, 01 opcode fetch, 10/11 data access |
| busAddr | input | 16 | Bus address |
| busData | input | 16 | Bus data |
| busWrite | input | 1 | Bus cycle is a write |
| busWord | input | 1 | Bus cycle is a word (not byte) access |
| rdStrobe | input | 1 | Read strobe; advances the readout pointer |
| rdData | output | 16 | Word at the readout pointer |
| entryCnt | output | 7 | Number of stored lines |
| wrapped | output | 1 | Oldest lines have been overwritten |

## Verification
The assertions assume that `traceArm`, `secure` and `rdStrobe` are synchronous to `clk` and held stable from one edge to the next. They also assume the reader only drains the buffer after a session has ended. The stimulus changes every input on the falling clock edge only. It never pulses `rdStrobe` in the cycle where `traceArm` drops. It holds `modeSel` constant for a whole session, so each session exercises exactly one capture filter.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    MODE_FLOW       = 2'd0,
    MODE_FLOW_DEDUP = 2'd1,
    MODE_DETAIL     = 2'd2,
    MODE_ALLPC      = 2'd3
  } trc_mode_e;

  localparam logic [1:0] KIND_FREE  = 2'b00;
  localparam logic [1:0] KIND_FETCH = 2'b01;

  localparam int WORDS_PER_LINE = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // write the assembled line this edge
    logic mute;   // force read data to zero
  } trc_stb_t;

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          traceArm,
  input  logic          secure,
  input  trc_mode_e     mode,
  input  logic          pcValid,
  input  logic          cofValid,
  input  logic [DW-1:0] cpuPc,
  input  logic [1:0]    cycKind,
  input  logic          rdStrobe,
  output trc_stb_t      stb,
  output logic [LW-1:0] wrLine,
  output logic [LW-1:0] rdLine,
  output logic [1:0]    rdWord,
  output logic [CW-1:0] entryCnt,
  output logic          wrapped
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [LW-1:0] LAST_LINE = LW'(DEPTH - 1);

  logic          armQ;
  logic [LW-1:0] wrPtr;
  logic [CW-1:0] cnt;
  logic          wrapQ;
  logic [DW-1:0] lastSrc;
  logic          lastOk;

  logic          sessStart, sessStop;
  logic [LW-1:0] baseWr;
  logic [CW-1:0] baseCnt;
  logic          baseLastOk;
  logic          qualify, capture, isFull;

  assign sessStart  = traceArm & ~armQ;
  assign sessStop   = ~traceArm & armQ;
  assign baseWr     = sessStart ? '0 : wrPtr;
  assign baseCnt    = sessStart ? '0 : cnt;
  assign baseLastOk = sessStart ? 1'b0 : lastOk;
  assign isFull     = (baseCnt == FULL_CNT);

  always_comb begin
    unique case (mode)
      MODE_FLOW:       qualify = cofValid;
      MODE_FLOW_DEDUP: qualify = cofValid & ~(baseLastOk & (lastSrc == cpuPc));
      MODE_DETAIL:     qualify = (cycKind != KIND_FREE) && (cycKind != KIND_FETCH);
      default:         qualify = pcValid;
    endcase
  end

  assign capture = traceArm & ~secure & qualify;

  // Write side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ    <= 1'b0;
      wrPtr   <= '0;
      cnt     <= '0;
      wrapQ   <= 1'b0;
      lastSrc <= '0;
      lastOk  <= 1'b0;
    end else begin
      armQ <= traceArm;
      if (sessStart) begin
        wrPtr  <= '0;
        cnt    <= '0;
        wrapQ  <= 1'b0;
        lastOk <= 1'b0;
      end
      if (capture) begin
        wrPtr   <= (baseWr == LAST_LINE) ? '0 : baseWr + 1'b1;
        cnt     <= isFull ? baseCnt : baseCnt + 1'b1;
        wrapQ   <= (sessStart ? 1'b0 : wrapQ) | isFull;
        lastSrc <= cpuPc;
        lastOk  <= 1'b1;
      end
    end
  end

  // Read side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLine <= '0;
      rdWord <= '0;
    end else if (sessStop) begin
      rdLine <= wrapQ ? wrPtr : '0;
      rdWord <= '0;
    end else if (rdStrobe && !traceArm) begin
      if (rdWord == 2'(WORDS_PER_LINE - 1)) begin
        rdWord <= '0;
        rdLine <= (rdLine == LAST_LINE) ? '0 : rdLine + 1'b1;
      end else begin
        rdWord <= rdWord + 1'b1;
      end
    end
  end

  assign stb.wrEn = capture;
  assign stb.mute = traceArm | (cnt == '0);
  assign wrLine   = baseWr;
  assign entryCnt = cnt;
  assign wrapped  = wrapQ;

endmodule

// File: rtl/trc_data.sv
module trc_data
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW = 16,
  localparam int LW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  trc_stb_t      stb,
  input  trc_mode_e     mode,
  input  logic [LW-1:0] wrLine,
  input  logic [LW-1:0] rdLine,
  input  logic [1:0]    rdWord,
  input  logic [DW-1:0] cpuPc,
  input  logic [DW-1:0] cofDest,
  input  logic [DW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  input  logic          busWrite,
  input  logic          busWord,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] store [DEPTH][WORDS_PER_LINE];
  logic [DW-1:0] newWord [WORDS_PER_LINE];
  logic          isDetail;

  assign isDetail = (mode == MODE_DETAIL);

  always_comb begin
    newWord[0]      = '0;
    newWord[0][1:0] = mode;
    newWord[0][2]   = isDetail & busWrite;
    newWord[0][3]   = isDetail & busWord;
    newWord[1]      = isDetail ? busAddr : cpuPc;
    if (isDetail)                newWord[2] = busData;
    else if (mode == MODE_ALLPC) newWord[2] = '0;
    else                         newWord[2] = cofDest;
  end

  for (genvar w = 0; w < WORDS_PER_LINE; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (stb.wrEn) store[wrLine][w] <= newWord[w];
    end
  end

  always_comb begin
    if (stb.mute || rdWord >= 2'(WORDS_PER_LINE)) rdData = '0;
    else                                           rdData = store[rdLine][rdWord];
  end

endmodule

// File: rtl/trace_buf.sv
module trace_buf
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW = 16,
  localparam int LW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          traceArm,
  input  logic          secure,
  input  logic [1:0]    modeSel,
  input  logic          pcValid,
  input  logic [DW-1:0] cpuPc,
  input  logic          cofValid,
  input  logic [DW-1:0] cofDest,
  input  logic [1:0]    cycKind,
  input  logic [DW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  input  logic          busWrite,
  input  logic          busWord,
  input  logic          rdStrobe,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] entryCnt,
  output logic          wrapped
);

  trc_mode_e     mode;
  trc_stb_t      stb;
  logic [LW-1:0] wrLine, rdLine;
  logic [1:0]    rdWord;

  assign mode = trc_mode_e'(modeSel);

  trc_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .traceArm(traceArm), .secure(secure),
    .mode(mode), .pcValid(pcValid), .cofValid(cofValid), .cpuPc(cpuPc),
    .cycKind(cycKind), .rdStrobe(rdStrobe), .stb(stb), .wrLine(wrLine),
    .rdLine(rdLine), .rdWord(rdWord), .entryCnt(entryCnt), .wrapped(wrapped)
  );

  trc_data #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk(clk), .stb(stb), .mode(mode), .wrLine(wrLine), .rdLine(rdLine),
    .rdWord(rdWord), .cpuPc(cpuPc), .cofDest(cofDest), .busAddr(busAddr),
    .busData(busData), .busWrite(busWrite), .busWord(busWord), .rdData(rdData)
  );

endmodule

// File: rtl/trc_chk.sv
module trc_chk #(
  parameter int DEPTH = 64,
  parameter int DW = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          traceArm,
  input logic          secure,
  input logic [DW-1:0] rdData,
  input logic [CW-1:0] entryCnt,
  input logic          wrapped
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    entryCnt <= CW'(DEPTH)); // R8

  AST_WRAP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    wrapped |-> entryCnt == CW'(DEPTH)); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    traceArm |=> {1'b0, entryCnt} <= {1'b0, $past(entryCnt)} + 1'b1); // R8

  AST_MUTE_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    traceArm |-> rdData == '0); // R10

  AST_MUTE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    entryCnt == '0 |-> rdData == '0); // R10

  AST_SECURE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (secure && traceArm && $past(traceArm)) |=> $stable(entryCnt)); // R7

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !traceArm |=> $stable(entryCnt) && $stable(wrapped)); // R2

endmodule

bind trace_buf trc_chk #(.DEPTH(DEPTH), .DW(DW)) u_trc_chk (
  .clk(clk), .rstN(rstN), .traceArm(traceArm), .secure(secure),
  .rdData(rdData), .entryCnt(entryCnt), .wrapped(wrapped)
);

// File: tb/trace_buf_bench.sv
module trace_buf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        traceArm = 1'b0, secure = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic        pcValid = 1'b0, cofValid = 1'b0;
  logic [15:0] cpuPc = '0, cofDest = '0, busAddr = '0, busData = '0;
  logic [1:0]  cycKind = 2'b00;
  logic        busWrite = 1'b0, busWord = 1'b0, rdStrobe = 1'b0;
  logic [15:0] rdData;
  logic [6:0]  entryCnt;
  logic        wrapped;

  int checks = 0, fails = 0;

  // bench model of stored lines
  logic [15:0] expW [256][3];
  int          expN;
  logic [15:0] mLastSrc;
  bit          mLastOk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_buf u_trace_buf (
    .clk(clk), .rstN(rstN), .traceArm(traceArm), .secure(secure),
    .modeSel(modeSel), .pcValid(pcValid), .cpuPc(cpuPc), .cofValid(cofValid),
    .cofDest(cofDest), .cycKind(cycKind), .busAddr(busAddr), .busData(busData),
    .busWrite(busWrite), .busWord(busWord), .rdStrobe(rdStrobe),
    .rdData(rdData), .entryCnt(entryCnt), .wrapped(wrapped)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Start a session (no qualifying event in the start cycle)
  task automatic armSession(input logic [1:0] m, input logic sec);
    modeSel = m; secure = sec; traceArm = 1'b1;
    expN = 0; mLastOk = 1'b0;
    @(negedge clk);
  endtask

  // One capture cycle; model decides whether a line is stored
  task automatic step(input logic pcv, input logic cof, input logic [15:0] pc,
                      input logic [15:0] dst, input logic [1:0] kind,
                      input logic wr, input logic wd,
                      input logic [15:0] addr, input logic [15:0] data);
    bit take;
    logic [15:0] h;
    pcValid = pcv; cofValid = cof; cpuPc = pc; cofDest = dst; cycKind = kind;
    busWrite = wr; busWord = wd; busAddr = addr; busData = data;
    case (modeSel)
      2'd0: take = cof;
      2'd1: take = cof && !(mLastOk && mLastSrc == pc);
      2'd2: take = (kind == 2'b10) || (kind == 2'b11);
      default: take = pcv;
    endcase
    if (secure) take = 0;
    if (take) begin
      h = {14'd0, modeSel};
      if (modeSel == 2'd2) h = h | (16'(wr) << 2) | (16'(wd) << 3);
      expW[expN][0] = h;
      expW[expN][1] = (modeSel == 2'd2) ? addr : pc;
      expW[expN][2] = (modeSel == 2'd2) ? data : (modeSel == 2'd3) ? 16'h0 : dst;
      expN++;
      mLastSrc = pc; mLastOk = 1'b1;
    end
    @(negedge clk);
    // R10: muted while armed
    chk(rdData, 16'h0, "R10 armed read");
  endtask

  task automatic idleIn;
    pcValid = 0; cofValid = 0; cycKind = 2'b00;
  endtask

  // End session, check counters, drain and compare
  task automatic drain(input string req);
    int n, first;
    idleIn();
    traceArm = 1'b0;
    @(negedge clk);
    n     = (expN > DEPTH) ? DEPTH : expN;
    first = (expN > DEPTH) ? expN - DEPTH : 0;
    chk(32'(entryCnt), 32'(n), {req, " / R8 count"});
    chk(32'(wrapped), 32'(expN > DEPTH), {req, " / R8 wrap"});
    for (int i = 0; i < n; i++) begin
      for (int w = 0; w < 3; w++) begin
        chk(32'(rdData), 32'(expW[first + i][w]), {req, " / R9 readout"});
        rdStrobe = 1'b1;
        @(negedge clk);
        rdStrobe = 1'b0;
      end
    end
    secure = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(32'(entryCnt), 0, "R1 count");
    chk(32'(wrapped), 0, "R1 wrap");
    chk(32'(rdData), 0, "R1 data");

    // R6: every PC
    armSession(2'd3, 1'b0);
    for (int i = 0; i < 12; i++)
      step(i % 3 != 2, 1'b1, 16'h1000 + 16'(i * 3), 16'hBEEF, 2'b10, 1, 1, 16'h5555, 16'hAAAA);
    drain("R6 all-PC");

    // R3: flow mode, sparse change-of-flow
    armSession(2'd0, 1'b0);
    for (int i = 0; i < 16; i++)
      step(1'b1, (i % 4) == 1 || i == 6, 16'h4000 + 16'(i), 16'h8000 + 16'(i * 16), 2'b10, 0, 0, 16'h0, 16'h0);
    drain("R3 flow");

    // R4: dedup of back-to-back sources, non-adjacent repeat kept
    armSession(2'd1, 1'b0);
    step(0, 1, 16'h0100, 16'h0200, 2'b00, 0, 0, 0, 0);
    step(0, 1, 16'h0100, 16'h0204, 2'b00, 0, 0, 0, 0);
    step(0, 0, 16'h0150, 16'h0000, 2'b00, 0, 0, 0, 0);
    step(0, 1, 16'h0100, 16'h0208, 2'b00, 0, 0, 0, 0);
    step(0, 1, 16'h0300, 16'h0400, 2'b00, 0, 0, 0, 0);
    step(0, 1, 16'h0100, 16'h0500, 2'b00, 0, 0, 0, 0);
    step(0, 1, 16'h0100, 16'h0504, 2'b00, 0, 0, 0, 0);
    drain("R4 dedup");

    // R5: detail sweep over kind x direction x size
    armSession(2'd2, 1'b0);
    for (int i = 0; i < 16; i++)
      step(1, 1, 16'h7777, 16'h6666, 2'(i), i[2], i[3], 16'h2000 + 16'(i), 16'(i) * 16'h1111 ^ 16'h0F0F);
    drain("R5 detail");

    // R7: secure blocks capture
    armSession(2'd3, 1'b1);
    for (int i = 0; i < 8; i++)
      step(1, 1, 16'h3000 + 16'(i), 16'h0, 2'b10, 0, 0, 0, 0);
    chk(32'(entryCnt), 0, "R7 secure count");
    drain("R7 secure");
    chk(32'(rdData), 0, "R10 empty read");

    // R8/R9: wrap-around with 70 lines, plus R10 strobe ignored while armed
    armSession(2'd3, 1'b0);
    for (int i = 0; i < 70; i++) begin
      rdStrobe = (i == 5);
      step(1, 0, 16'hC000 + 16'(i * 2), 16'h0, 2'b00, 0, 0, 0, 0);
    end
    rdStrobe = 1'b0;
    drain("R8 wrap");

    // R2: rearm clears buffer and wrap flag
    armSession(2'd0, 1'b0);
    step(0, 1, 16'hAB00, 16'hCD00, 2'b00, 0, 0, 0, 0);
    drain("R2 rearm");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule